// File: doc/BRIEF.md
# Parallel Converter Host Sequencer

This block sits on the system side of a 14-bit parallel-output sampling converter. After the system reset it pulls the converter's active-low reset line low for a set number of cycles. If enabled, it then writes one offset word over the shared data bus. After that it serves conversion triggers. A trigger comes from a one-cycle request input or from an internal period timer. For each trigger the block pulses convert-start low and waits until the converter's busy line has gone low and then come back high. It then lowers chip-select and read together, lets the bus settle, captures the word, and releases read. The captured 14-bit sample and its overrange bit are presented with a one-cycle valid flag.

The converter can run in two latch modes. In the immediate mode the result is in the output register when busy rises. In the delayed mode the output register is only updated at the next convert-start edge, so every read returns the previous conversion. In that mode the block drops the first read after reset, which holds no real sample. If busy does not return high within a programmable limit, the block gives up on that conversion and sets a sticky error flag.

Top module: `adc_host_ctrl`

## Requirements
- R1: After `rst_n` is released, `cnv_rst_n` stays low for exactly RST_W clock cycles. While `cnv_rst_n` is low, `cnv_start_n` and `cnv_cs_n` are high, `cnv_wr` is low, and `ready`, `smp_valid` and `busy_err` are low.
- R2: When `offset_en` is high at reset, exactly one offset write follows the converter reset. `cnv_wr` is high for WR_W cycles. `cnv_cs_n` is low and `cnv_dq_oe` is high, carrying `offset_word` on `cnv_dq_out`, from one cycle before `cnv_wr` rises until one cycle after it falls. When `offset_en` is low, no write occurs.
- R3: Each accepted trigger gives one `cnv_start_n` low pulse of CNV_W cycles. A trigger that arrives during a conversion is kept as a single pending trigger. A request and a timer tick in the same cycle give one conversion.
- R4: With `period` nonzero, the timer fires at the period-th rising edge after `ready` goes high and then every `period` cycles. With `period` zero it never fires.
- R5: The read strobe (`cnv_cs_n` and `cnv_rd_n` both low) starts only after busy has been seen low and then high again. It lasts SETTLE_W cycles and is followed by at least one cycle with `cnv_rd_n` high.
- R6: With `lat_delayed` = 0, every read gives one single-cycle `smp_valid`. `smp_data` is `cnv_dq_in[13:0]` and `smp_ovr` is `cnv_dq_in[14]`, the overrange bit, both taken in the last read cycle.
- R7: With `lat_delayed` = 1, the first read after reset raises no `smp_valid`. Every later read is forwarded as in R6, so it carries the previous conversion's result.
- R8: If busy has not completed its low-then-high return within `busy_limit` cycles of entering the wait, no read is made for that conversion. `busy_err` then rises and stays high until reset.
- R9: `cnv_dq_oe` is never high while `cnv_rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_delayed | input | 1 | 1: converter uses delayed latch mode |
| offset_en | input | 1 | Perform the offset write after reset |
| offset_word | input | 14 | Offset value to write |
| period | input | 16 | Sample period in cycles, 0 disables the timer |
| busy_limit | input | 12 | Busy timeout in cycles |
| req | input | 1 | One-cycle conversion request |
| cnv_rst_n | output | 1 | Converter reset, active low |
| cnv_start_n | output | 1 | Convert start, falling edge starts |
| cnv_busy | input | 1 | Converter busy, low while converting |
| cnv_cs_n | output | 1 | Chip select, active low |
| cnv_rd_n | output | 1 | Read strobe, active low |
| cnv_wr | output | 1 | Offset write pulse, active high |
| cnv_dq_in | input | 15 | Data bus in: bit 14 overrange, bits 13:0 sample |
| cnv_dq_out | output | 14 | Data bus out (offset word) |
| cnv_dq_oe | output | 1 | Bus output enable |
| smp_data | output | 14 | Captured sample |
| smp_ovr | output | 1 | Captured overrange bit |
| smp_valid | output | 1 | Sample valid, one cycle |
| busy_err | output | 1 | Sticky busy timeout flag |
| ready | output | 1 | Power-up sequence finished |

## Verification
The two sources of triggers can land on the same edge: an external request and a period timer tick. They must merge into one conversion, not two. The bench waits for `ready` to rise, counts clock edges to the first tick, and drives `req` so that it is sampled on exactly that edge. Its converter model counts convert-start falling edges, and the bench judges the merge by that count staying at one. A separate burst of requests during a running conversion checks that several late triggers collapse into exactly one follow-up conversion.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [3:0] {
    ST_RST, ST_OFS_SET, ST_OFS_WR, ST_OFS_HOLD,
    ST_IDLE, ST_CONV, ST_WAIT, ST_READ, ST_GAP
  } host_st_e;

  // True on the last cycle of a span that lasts w cycles, counted from c = 0
  function automatic logic span_done(input logic [CNT_W-1:0] c, input int unsigned w);
    return ({24'd0, c} + 32'd1) >= w;
  endfunction
endpackage

// File: rtl/adc_period_tick.sv
module adc_period_tick #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt;

  assign tick = en && (period != '0) && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!en || period == '0)     cnt <= '0;
    else if (tick)                    cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period > 1) |=> (!tick || !$stable(period)));
endmodule

// File: rtl/adc_busy_watch.sv
module adc_busy_watch #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          arm,
  input  logic          run,
  input  logic          busy_in,
  input  logic [TW-1:0] lim,
  output logic          conv_done,
  output logic          tmo_hit,
  output logic          err
);
  logic [TW-1:0] cnt;
  logic          seen_low;

  assign conv_done = seen_low && busy_in;
  assign tmo_hit   = run && !conv_done && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; seen_low <= 1'b0; err <= 1'b0;
    end else begin
      if (clr) begin
        cnt <= '0; seen_low <= 1'b0;
      end else begin
        if (run && cnt != '1) cnt <= cnt + 1'b1;
        if (arm && !busy_in)  seen_low <= 1'b1;
      end
      if (tmo_hit) err <= 1'b1;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/adc_sample_capture.sv
module adc_sample_capture #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          delayed,
  input  logic [DW:0]   bus_in,
  output logic [DW-1:0] data,
  output logic          ovr,
  output logic          valid
);
  logic primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0; valid <= 1'b0; data <= '0; ovr <= 1'b0;
    end else begin
      valid <= cap && (!delayed || primed);
      if (cap) begin
        primed <= 1'b1;
        data   <= bus_in[DW-1:0];
        ovr    <= bus_in[DW];
      end
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DW       = 14,
  parameter int PERIOD_W = 16,
  parameter int TMO_W    = 12,
  parameter int RST_W    = 2,
  parameter int CNV_W    = 2,
  parameter int WR_W     = 2,
  parameter int SETTLE_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lat_delayed,
  input  logic                offset_en,
  input  logic [DW-1:0]       offset_word,
  input  logic [PERIOD_W-1:0] period,
  input  logic [TMO_W-1:0]    busy_limit,
  input  logic                req,
  output logic                cnv_rst_n,
  output logic                cnv_start_n,
  input  logic                cnv_busy,
  output logic                cnv_cs_n,
  output logic                cnv_rd_n,
  output logic                cnv_wr,
  input  logic [DW:0]         cnv_dq_in,
  output logic [DW-1:0]       cnv_dq_out,
  output logic                cnv_dq_oe,
  output logic [DW-1:0]       smp_data,
  output logic                smp_ovr,
  output logic                smp_valid,
  output logic                busy_err,
  output logic                ready
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  host_st_e         st, st_nx;
  logic [CNT_W-1:0] cnt;
  logic             pend;

  // named internal events
  logic tick, trig, start_ev, cap_ev, conv_done, tmo_hit, in_ofs;

  assign trig     = req | tick;
  assign start_ev = (st == ST_IDLE) && (pend || trig);
  assign cap_ev   = (st == ST_READ) && span_done(cnt, SETTLE_W);
  assign in_ofs   = (st == ST_OFS_SET) || (st == ST_OFS_WR) || (st == ST_OFS_HOLD);

  adc_period_tick #(.PW(PERIOD_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(ready), .period(period), .tick(tick)
  );

  adc_busy_watch #(.TW(TMO_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .clr(start_ev),
    .arm((st == ST_CONV) || (st == ST_WAIT)), .run(st == ST_WAIT),
    .busy_in(cnv_busy), .lim(busy_limit),
    .conv_done(conv_done), .tmo_hit(tmo_hit), .err(busy_err)
  );

  adc_sample_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(cap_ev), .delayed(lat_delayed),
    .bus_in(cnv_dq_in), .data(smp_data), .ovr(smp_ovr), .valid(smp_valid)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_RST:      if (span_done(cnt, RST_W)) st_nx = offset_en ? ST_OFS_SET : ST_IDLE;
      ST_OFS_SET:  st_nx = ST_OFS_WR;
      ST_OFS_WR:   if (span_done(cnt, WR_W)) st_nx = ST_OFS_HOLD;
      ST_OFS_HOLD: st_nx = ST_IDLE;
      ST_IDLE:     if (start_ev) st_nx = ST_CONV;
      ST_CONV:     if (span_done(cnt, CNV_W)) st_nx = ST_WAIT;
      ST_WAIT:     if (conv_done) st_nx = ST_READ;
                   else if (tmo_hit) st_nx = ST_IDLE;
      ST_READ:     if (cap_ev) st_nx = ST_GAP;
      ST_GAP:      st_nx = ST_IDLE;
      default:     st_nx = ST_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_RST; cnt <= '0; pend <= 1'b0;
    end else begin
      st <= st_nx;
      if (st_nx != st)         cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (start_ev)  pend <= 1'b0;
      else if (trig) pend <= 1'b1;
    end
  end

  assign cnv_rst_n   = (st != ST_RST);
  assign cnv_start_n = (st != ST_CONV);
  assign cnv_rd_n    = (st != ST_READ);
  assign cnv_cs_n    = !(in_ofs || st == ST_READ);
  assign cnv_wr      = (st == ST_OFS_WR);
  assign cnv_dq_oe   = in_ofs;
  assign cnv_dq_out  = offset_word;
  assign ready       = !(in_ofs || st == ST_RST);

  // R9
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_dq_oe |-> cnv_rd_n);
  // R1
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_rst_n |-> (cnv_start_n && cnv_cs_n && !cnv_wr && !smp_valid));
  // R2
  wr_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_wr |-> (!cnv_cs_n && cnv_dq_oe));
  // R5
  read_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_rd_n) |-> cnv_busy);
  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_rd_n) |=> cnv_rd_n);
endmodule

// File: tb/sim_adc_host_ctrl.sv
`timescale 1ns/1ps
module sim_adc_host_ctrl;
  localparam int CNV_W = 2, SETTLE_W = 2, RST_W = 2, CONV_CYC = 5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lat_delayed = 1'b0, offset_en = 1'b0, req = 1'b0;
  logic [13:0] offset_word = 14'h2A5C;
  logic [15:0] period = '0;
  logic [11:0] busy_limit = 12'd20;
  logic        cnv_rst_n, cnv_start_n, cnv_cs_n, cnv_rd_n, cnv_wr, cnv_dq_oe;
  logic [14:0] cnv_dq_in;
  logic [13:0] cnv_dq_out, smp_data;
  logic        smp_ovr, smp_valid, busy_err, ready;

  always #4 clk = ~clk;

  // converter model
  logic        busy_m = 1'b1, stuck = 1'b0, wr_q = 1'b0, st_q = 1'b1;
  logic [14:0] out_reg = '0;
  logic [13:0] ofs_latched = '0;
  int          n_conv = 0, n_wr = 0, bcnt = 0;
  logic [14:0] expq[$];

  int checks = 0, fails = 0, nvalid = 0, lowrun = 0, rdrun = 0;
  bit done = 0;

  adc_host_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .lat_delayed(lat_delayed), .offset_en(offset_en),
    .offset_word(offset_word), .period(period), .busy_limit(busy_limit), .req(req),
    .cnv_rst_n(cnv_rst_n), .cnv_start_n(cnv_start_n), .cnv_busy(busy_m),
    .cnv_cs_n(cnv_cs_n), .cnv_rd_n(cnv_rd_n), .cnv_wr(cnv_wr), .cnv_dq_in(cnv_dq_in),
    .cnv_dq_out(cnv_dq_out), .cnv_dq_oe(cnv_dq_oe), .smp_data(smp_data),
    .smp_ovr(smp_ovr), .smp_valid(smp_valid), .busy_err(busy_err), .ready(ready)
  );

  function automatic logic [14:0] fres(input int k);
    if (k % 5 == 2) return 15'h3FFF;
    return 15'((k * 1237 + 301) & 32'h7FFF);
  endfunction

  assign cnv_dq_in = (!cnv_cs_n && !cnv_rd_n) ? out_reg : 15'h1234;

  always @(posedge clk) begin
    wr_q <= cnv_wr;
    st_q <= cnv_start_n;
    if (!cnv_rst_n) begin
      busy_m <= 1'b1; out_reg <= '0; n_conv <= 0; n_wr <= 0; bcnt <= 0; ofs_latched <= '0;
    end else begin
      if (wr_q && !cnv_wr && !cnv_cs_n) begin
        ofs_latched <= cnv_dq_out; n_wr <= n_wr + 1;
      end
      if (st_q && !cnv_start_n) begin
        busy_m <= 1'b0; bcnt <= CONV_CYC; n_conv <= n_conv + 1;
        if (lat_delayed && n_conv > 0) begin
          out_reg <= fres(n_conv - 1); expq.push_back(fres(n_conv - 1));
        end
      end else if (!busy_m && !stuck) begin
        if (bcnt == 1) begin
          busy_m <= 1'b1;
          if (!lat_delayed) begin
            out_reg <= fres(n_conv - 1); expq.push_back(fres(n_conv - 1));
          end
        end else bcnt <= bcnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  // monitor: scoreboard pop and strobe widths
  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_valid) begin
        nvalid++;
        if (expq.size() == 0) check(0, lat_delayed ? "R7 unexpected" : "R6 unexpected",
                                    {smp_ovr, smp_data}, 0);
        else begin
          logic [14:0] e;
          e = expq.pop_front();
          check({smp_ovr, smp_data} === e, lat_delayed ? "R7 data" : "R6 data",
                {smp_ovr, smp_data}, e);
        end
      end
      if (!cnv_start_n) lowrun++;
      else if (lowrun > 0) begin check(lowrun == CNV_W, "R3 start width", lowrun, CNV_W); lowrun = 0; end
      if (!cnv_rd_n) begin
        if (rdrun == 0) check(busy_m && !cnv_cs_n && !cnv_dq_oe, "R5 R9 read entry",
                              {busy_m, cnv_cs_n, cnv_dq_oe}, 3'b100);
        rdrun++;
      end else if (rdrun > 0) begin
        check(rdrun == SETTLE_W, "R5 read width", rdrun, SETTLE_W); rdrun = 0;
      end
    end
  end

  task automatic do_reset(input bit lat, input bit ofs, input int per);
    int n;
    @(negedge clk);
    rst_n = 1'b0; lat_delayed = lat; offset_en = ofs; period = 16'(per);
    repeat (3) @(negedge clk);
    check(!ready && !smp_valid && !busy_err && !cnv_rst_n && cnv_start_n && cnv_cs_n && !cnv_wr,
          "R1 reset state", {ready, smp_valid, busy_err, cnv_rst_n}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!cnv_rst_n) begin n++; @(negedge clk); end
    check(n == RST_W, "R1 reset width", n, RST_W);
    while (!ready) @(negedge clk);
  endtask

  task automatic pulse_req();
    req = 1'b1; @(negedge clk); req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, vb;
    // Phase A: immediate mode, offset write, coincident triggers
    do_reset(1'b0, 1'b1, 40);
    check(n_wr == 1, "R2 write count", n_wr, 1);
    check(ofs_latched == offset_word, "R2 offset word", ofs_latched, offset_word);
    repeat (39) @(posedge clk);
    @(negedge clk); req = 1'b1;          // sampled on the same edge as the first tick
    @(negedge clk); req = 1'b0;
    repeat (24) @(negedge clk);
    check(n_conv == 1, "R3 merged request and tick", n_conv, 1);
    repeat (100) @(negedge clk);
    check(n_conv == 4, "R4 periodic ticks", n_conv, 4);
    period = '0;
    repeat (100) @(negedge clk);
    check(n_conv == 4, "R4 timer disabled", n_conv, 4);
    check(expq.size() == 0 && nvalid == 4, "R6 all samples out", nvalid, 4);
    base = n_conv;
    pulse_req(); repeat (3) @(negedge clk); pulse_req(); repeat (2) @(negedge clk); pulse_req();
    repeat (60) @(negedge clk);
    check(n_conv - base == 2, "R3 pending kept once", n_conv - base, 2);
    check(expq.size() == 0 && nvalid == 6, "R6 pending samples", nvalid, 6);

    // Phase B: delayed latch mode, no offset write
    do_reset(1'b1, 1'b0, 0);
    check(n_wr == 0, "R2 no write", n_wr, 0);
    vb = nvalid;
    for (int i = 0; i < 4; i++) begin pulse_req(); repeat (30) @(negedge clk); end
    check(n_conv == 4, "R7 conversions", n_conv, 4);
    check(nvalid - vb == 3, "R7 first read dropped", nvalid - vb, 3);
    check(expq.size() == 0, "R7 queue drained", expq.size(), 0);

    // Phase C: busy timeout
    do_reset(1'b0, 1'b0, 0);
    stuck = 1'b1; busy_limit = 12'd20; vb = nvalid;
    pulse_req();
    repeat (10) @(negedge clk);
    check(!busy_err, "R8 no early error", busy_err, 0);
    repeat (50) @(negedge clk);
    check(busy_err, "R8 error raised", busy_err, 1);
    check(nvalid == vb && cnv_rd_n, "R8 no read", nvalid - vb, 0);
    repeat (20) @(negedge clk);
    check(busy_err, "R8 error held", busy_err, 1);
    stuck = 1'b0;

    // Phase D: recovery after reset
    do_reset(1'b0, 1'b0, 0);
    check(!busy_err, "R8 cleared by reset", busy_err, 0);
    vb = nvalid;
    pulse_req(); repeat (30) @(negedge clk);
    check(nvalid - vb == 1 && expq.size() == 0, "R6 after recovery", nvalid - vb, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule